// File: doc/BRIEF.md
# Fixed-Weight Subset Mask Generator

This block walks through the N-bit masks that carry exactly K set bits, in strictly decreasing numeric order, and hands out one contiguous slice of that walk to a single worker. A mask bit at position i is 1 exactly when element i belongs to the subset. Rank 0 is the mask with the K highest bits set. The last rank, C(N,K)-1, is the mask with the K lowest bits set.

A start pulse captures N, K, the worker index r and the worker count P. The block works out its slice bounds from these values. It converts the first rank of the slice into a mask by combinatorial unranking, testing one candidate bit position per cycle. After that it emits one successor mask per accepted handshake, using a trailing-ones / trailing-zeros step. Every worker therefore gets a slice of equal popcount and near-equal size, and no worker has to step through ranks it does not own.

The binomial coefficients come from a Pascal triangle built in combinational logic up to the parameter NMAX.

Top module: `subset_mask_gen`

## Requirements
- R1: Every emitted mask has exactly K bits set, where bit i set means element i is in the subset.
- R2: Emitted masks fall in strictly decreasing numeric order, with no K-weight value skipped between two consecutive masks. Rank 0 is the K highest bits set. For example, with N=6 the step from 010011 gives 001110.
- R3: The first mask emitted for a slice is the mask of rank lo = floor(C(N,K)*r/P).
- R4: A slice holds exactly floor(C(N,K)*(r+1)/P) - lo masks. Over r = 0..P-1 the slices together cover all C(N,K) masks once each.
- R5: m_last is 1 on the final mask of a slice and 0 on every other emitted mask.
- R6: While m_valid is 1 and m_ready is 0, m_data and m_last hold steady. The stream advances by exactly one mask for each cycle in which both are 1.
- R7: busy is 1 from the cycle after start is accepted until the first mask is valid. The first mask is valid after at most N+1 busy cycles. busy and m_valid are never 1 together.
- R8: A slice of zero length emits no mask. busy returns to 0 and the block accepts a new start.
- R9: A start pulse is ignored while the block is busy or streaming. The slice in progress continues unchanged.
- R10: K=0 yields the single mask 0, and K=N yields the single all-ones mask of width N. Each carries m_last.
- R11: After reset, busy and m_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a slice when the block is idle |
| n_in | input | NW | Set size N, 1..NMAX |
| k_in | input | NW | Popcount K, 0..N |
| worker_idx | input | PW | Worker index r, less than worker_cnt |
| worker_cnt | input | PW | Worker count P, at least 1 |
| busy | output | 1 | Unranking in progress |
| m_valid | output | 1 | Mask available |
| m_ready | input | 1 | Consumer accepts the mask |
| m_data | output | NMAX | Current subset mask |
| m_last | output | 1 | Final mask of the slice |

## Verification
The start pulse is captured on one rising edge. The first mask becomes valid after N+1 or fewer busy cycles, and a zero-length slice shows exactly one busy cycle. Each accepted mask is replaced by its successor on the very next edge. The bench drives inputs and samples outputs on the falling edge, which lets it count busy cycles exactly and treat a transfer as the falling-edge sample where both valid and ready are high. Each accepted mask is compared with a software enumeration that scans values downward and keeps those of popcount K. That enumeration starts at rank lo, and the bench checks order, count, the last flag, and that data holds during stalls.

// File: rtl/subset_mask_gen_pkg.sv
// Shared types for the subset mask generator.
package subset_mask_gen_pkg;

    // Controller states: waiting, unranking the first mask, streaming masks.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UNRANK = 2'd1,
        ST_STREAM = 2'd2
    } gen_state_e;

endpackage

// File: rtl/binom_rom.sv
// Binomial coefficient lookup with two read ports.
// The Pascal triangle is built in combinational logic, row by row, for
// 0 <= n,k <= NMAX. Out-of-range indices read as 0.
// Assumes CW >= NMAX, so that every coefficient fits.
module binom_rom #(
    parameter int NMAX = 16,
    parameter int NW   = $clog2(NMAX + 1),
    parameter int CW   = NMAX
) (
    input  logic [NW-1:0] a_n,
    input  logic [NW-1:0] a_k,
    input  logic [NW-1:0] b_n,
    input  logic [NW-1:0] b_k,
    output logic [CW-1:0] a_val,
    output logic [CW-1:0] b_val
);
    localparam logic [NW-1:0] NMAX_W = NW'(NMAX);

    logic [CW-1:0] tbl [0:NMAX][0:NMAX];

    // Each row is the pairwise sum of the row above it.
    for (genvar n = 0; n <= NMAX; n++) begin : g_row
        logic [CW-1:0] val [0:NMAX];
        for (genvar k = 0; k <= NMAX; k++) begin : g_col
            if (k == 0) begin : g_one
                assign val[k] = CW'(1);
            end else if (n == 0) begin : g_zero
                assign val[k] = '0;
            end else begin : g_sum
                assign val[k] = g_row[n-1].val[k-1] + g_row[n-1].val[k];
            end
            assign tbl[n][k] = val[k];
        end
    end

    // Port a read with range guard.
    always_comb begin
        a_val = '0;
        if (a_n <= NMAX_W && a_k <= NMAX_W) a_val = tbl[a_n][a_k];
    end

    // Port b read with range guard.
    always_comb begin
        b_val = '0;
        if (b_n <= NMAX_W && b_k <= NMAX_W) b_val = tbl[b_n][b_k];
    end
endmodule

// File: rtl/slice_bounds.sv
// Computes one worker's share of the ranks 0..total-1:
// lo = floor(total*idx/cnt) and count = floor(total*(idx+1)/cnt) - lo.
// Assumes idx < cnt. A count input of 0 is treated as 1.
module slice_bounds #(
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic [CW-1:0] total,
    input  logic [PW-1:0] idx,
    input  logic [PW-1:0] cnt,
    output logic [CW-1:0] lo,
    output logic [CW-1:0] count
);
    localparam int PRW = CW + PW + 1;

    logic [PRW-1:0] tot_e, div, prod_lo, prod_hi, lo_full, hi_full;

    // Widen operands, scale by index, and divide by the worker count.
    always_comb begin
        tot_e   = PRW'(total);
        div     = (cnt == '0) ? PRW'(1) : PRW'(cnt);
        prod_lo = tot_e * PRW'(idx);
        prod_hi = tot_e * (PRW'(idx) + PRW'(1));
        lo_full = prod_lo / div;
        hi_full = prod_hi / div;
        lo      = CW'(lo_full);
        count   = CW'(hi_full - lo_full);
    end
endmodule

// File: rtl/mask_succ.sv
// Next lower mask of equal popcount.
// With cto = trailing ones and x = cur with those ones cleared, and
// ctz = trailing zeros of x, the result is x - 2^(ctz-cto-1).
// Assumes cur is not the lowest mask of its weight; if it is, cur is returned.
module mask_succ #(
    parameter int NMAX = 16
) (
    input  logic [NMAX-1:0] cur,
    output logic [NMAX-1:0] nxt
);
    int              cto, ctz, sh;
    logic            run1, run2;
    logic [NMAX-1:0] low, x, step;

    // Trailing-ones count, clear them, trailing-zeros count, then subtract.
    always_comb begin
        run1 = 1'b1;
        cto  = 0;
        for (int i = 0; i < NMAX; i++) begin
            if (run1 && cur[i]) cto = cto + 1;
            else                run1 = 1'b0;
        end
        for (int i = 0; i < NMAX; i++) low[i] = (i < cto);
        x    = cur & ~low;
        run2 = 1'b1;
        ctz  = 0;
        for (int i = 0; i < NMAX; i++) begin
            if (run2 && !x[i]) ctz = ctz + 1;
            else               run2 = 1'b0;
        end
        sh = ctz - cto - 1;
        for (int i = 0; i < NMAX; i++) step[i] = (i == sh);
        nxt = (x == '0) ? cur : (x - step);
    end
endmodule

// File: rtl/subset_mask_gen.sv
// Fixed-weight subset mask generator.
// On start while idle, it captures N, K and the worker slice. It then
// unranks the slice's first rank, testing one candidate position per cycle
// from the high end, and streams successors on a valid/ready handshake.
// The end of the slice comes from a remaining-count register.
// Assumes 1 <= n_in <= NMAX, k_in <= n_in, worker_cnt >= 1 and
// worker_idx < worker_cnt.
module subset_mask_gen
    import subset_mask_gen_pkg::*;
#(
    parameter int NMAX = 16,
    parameter int PW   = 8,
    localparam int NW  = $clog2(NMAX + 1),
    localparam int CW  = NMAX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   n_in,
    input  logic [NW-1:0]   k_in,
    input  logic [PW-1:0]   worker_idx,
    input  logic [PW-1:0]   worker_cnt,
    output logic            busy,
    output logic            m_valid,
    input  logic            m_ready,
    output logic [NMAX-1:0] m_data,
    output logic            m_last
);
    gen_state_e      state;
    logic [NW-1:0]   n_q, k_q, ui, uj, bitpos;
    logic [CW-1:0]   urank, rem_q, total, lo, count, cand_cnt;
    logic [NMAX-1:0] mask_q, set_hot, nxt_mask;

    binom_rom #(.NMAX(NMAX), .NW(NW), .CW(CW)) u_rom (
        .a_n(n_in), .a_k(k_in),
        .b_n(n_q - uj - NW'(1)), .b_k(k_q - ui - NW'(1)),
        .a_val(total), .b_val(cand_cnt)
    );

    slice_bounds #(.CW(CW), .PW(PW)) u_bounds (
        .total(total), .idx(worker_idx), .cnt(worker_cnt),
        .lo(lo), .count(count)
    );

    mask_succ #(.NMAX(NMAX)) u_succ (.cur(mask_q), .nxt(nxt_mask));

    // One-hot of the bit the current candidate position would set.
    always_comb begin
        bitpos = n_q - uj - NW'(1);
        for (int i = 0; i < NMAX; i++) set_hot[i] = (bitpos == NW'(i));
    end

    // Controller: capture, unrank one candidate per cycle, then stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            n_q    <= '0;
            k_q    <= '0;
            ui     <= '0;
            uj     <= '0;
            urank  <= '0;
            rem_q  <= '0;
            mask_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    n_q    <= n_in;
                    k_q    <= k_in;
                    ui     <= '0;
                    uj     <= '0;
                    urank  <= lo;
                    rem_q  <= count;
                    mask_q <= '0;
                    state  <= ST_UNRANK;
                end
                ST_UNRANK: begin
                    if (rem_q == '0) begin
                        state <= ST_IDLE;
                    end else if (ui == k_q) begin
                        state <= ST_STREAM;
                    end else begin
                        uj <= uj + NW'(1);
                        if (cand_cnt > urank) begin
                            mask_q <= mask_q | set_hot;
                            ui     <= ui + NW'(1);
                        end else begin
                            urank  <= urank - cand_cnt;
                        end
                    end
                end
                ST_STREAM: if (m_ready) begin
                    if (rem_q == CW'(1)) begin
                        state <= ST_IDLE;
                    end else begin
                        mask_q <= nxt_mask;
                        rem_q  <= rem_q - CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and remaining count.
    always_comb begin
        busy    = (state == ST_UNRANK);
        m_valid = (state == ST_STREAM);
        m_data  = mask_q;
        m_last  = (state == ST_STREAM) && (rem_q == CW'(1));
    end
endmodule

// File: rtl/subset_mask_gen_chk.sv
// Protocol and ordering checker for subset_mask_gen, attached by bind.
// Observes the stream ports and the captured popcount.
module subset_mask_gen_chk #(
    parameter int NMAX = 16,
    parameter int NW   = $clog2(NMAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            m_valid,
    input logic            m_ready,
    input logic            m_last,
    input logic [NMAX-1:0] m_data,
    input logic [NW-1:0]   k_q
);
    // R1
    popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ($countones(m_data) == int'(k_q)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R2
    descending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !m_last) |=> (m_valid && (m_data < $past(m_data))));

    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> !m_valid);

    // R7
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && m_valid));
endmodule

bind subset_mask_gen subset_mask_gen_chk #(.NMAX(NMAX), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .m_valid(m_valid),
    .m_ready(m_ready), .m_last(m_last), .m_data(m_data), .k_q(k_q)
);

// File: tb/sim_subset_mask_gen.sv
// Directed bench for subset_mask_gen: one task per scenario.
module sim_subset_mask_gen;
    localparam int NMAX = 16;
    localparam int PW   = 8;
    localparam int NW   = $clog2(NMAX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NW-1:0]   n_in = '0;
    logic [NW-1:0]   k_in = '0;
    logic [PW-1:0]   worker_idx = '0;
    logic [PW-1:0]   worker_cnt = 8'd1;
    logic            busy, m_valid, m_last;
    logic            m_ready = 1'b0;
    logic [NMAX-1:0] m_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    longint slice_got = 0;

    subset_mask_gen #(.NMAX(NMAX), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in), .k_in(k_in),
        .worker_idx(worker_idx), .worker_cnt(worker_cnt), .busy(busy),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: got %0d cycles exp <= 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
        end
    endtask

    function automatic longint binom(input int n, input int k);
        longint c = 1;
        if (k > n) return 0;
        for (int i = 0; i < k; i++) c = c * (n - i) / (i + 1);
        return c;
    endfunction

    // Next lower value of popcount k below v (software enumeration).
    function automatic longint next_lower(input longint v, input int k);
        longint w = v - 1;
        while (w >= 0 && $countones(w[31:0]) != k) w = w - 1;
        return w;
    endfunction

    // Mask of rank r: scan downward from the top value.
    function automatic longint mask_of_rank(input int n, input int k, input longint r);
        longint w = (longint'(1) << n);
        for (longint i = 0; i <= r; i++) w = next_lower(w, k);
        return w;
    endfunction

    function automatic bit ready_pat(input int mode, input int c);
        case (mode)
            1: return (c % 3) != 0;
            2: return (c % 5) < 2;
            default: return 1'b1;
        endcase
    endfunction

    // Runs one slice and checks every output against the enumeration.
    task automatic run_slice(input int n, input int k, input int r, input int p,
                             input int mode, input bit inject);
        longint tot, lo, hi, num, exp_v, got, prev_d;
        int c, busy_cnt, waited;
        bit first, stalled, done, injected;
        tot = binom(n, k);
        lo = tot * r / p;
        hi = tot * (r + 1) / p;
        num = hi - lo;
        exp_v = (num > 0) ? mask_of_rank(n, k, lo) : 0;
        @(negedge clk);
        n_in = NW'(n); k_in = NW'(k);
        worker_idx = PW'(r); worker_cnt = PW'(p);
        start = 1'b1;
        m_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        got = 0; c = 0; busy_cnt = 0; waited = 0;
        first = 1'b1; stalled = 1'b0; done = (num == 0); injected = 1'b0; prev_d = 0;
        // the negedge just reached is the first sample after the capture edge
        while (!done && waited < 20000) begin
            m_ready = ready_pat(mode, c);
            if (inject && got == 2 && !injected) begin
                // R9: new start with other parameters while streaming
                start = 1'b1; n_in = NW'(n - 1); k_in = NW'(1);
                worker_idx = '0; worker_cnt = 8'd1;
                injected = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!m_valid && first) begin
                busy_cnt++;
                check(busy == 1'b1, "R7", "busy before first mask", busy, 1);
            end
            if (m_valid) begin
                if (first) begin
                    check(busy_cnt <= n + 1, "R7", "unrank cycles", busy_cnt, n + 1);
                    check(m_data == exp_v, "R3", "first mask", m_data, exp_v);
                    first = 1'b0;
                end
                if (stalled)
                    check(m_data == prev_d, "R6", "data held in stall", m_data, prev_d);
                if (m_ready) begin
                    check(m_data == exp_v, "R1/R2", "mask order", m_data, exp_v);
                    check(m_last == (got == num - 1), "R5", "last flag", m_last, got == num - 1);
                    got++;
                    exp_v = next_lower(exp_v, k);
                    if (m_last) done = 1'b1;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    prev_d = m_data;
                end
            end
            c++; waited++;
            @(negedge clk);
        end
        start = 1'b0;
        m_ready = 1'b1;
        // Quiet period: no further masks once the slice is over.
        for (int i = 0; i < 2 * n + 4; i++) begin
            if (m_valid) got++;
            @(negedge clk);
        end
        check(got == num, "R4", "slice mask count", got, num);
        check(!busy && !m_valid, "R8", "idle after slice", {busy, m_valid}, 0);
        slice_got = got;
    endtask

    // R11: reset state.
    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0, "R11", "busy after reset", busy, 0);
        check(m_valid == 1'b0, "R11", "valid after reset", m_valid, 0);
    endtask

    // R2: full enumeration N=6 K=3 (covers 010011 -> 001110), always ready.
    task automatic t_full();
        run_slice(6, 3, 0, 1, 0, 1'b0);
        check(slice_got == 20, "R2", "full pass size", slice_got, 20);
    endtask

    // R4: three workers cover all 70 masks of N=8 K=4, with stalls (R6).
    task automatic t_split();
        longint sum = 0;
        for (int r = 0; r < 3; r++) begin
            run_slice(8, 4, r, 3, 1, 1'b0);
            sum = sum + slice_got;
        end
        check(sum == 70, "R4", "union of slices", sum, 70);
    endtask

    // R3 and R7: deep unrank at N=16 K=8, worker 5 of 7, bursty ready.
    task automatic t_deep();
        run_slice(16, 8, 5, 7, 2, 1'b0);
    endtask

    // R8: an empty slice (C(4,4)=1 split over 3 workers, worker 0).
    task automatic t_empty();
        run_slice(4, 4, 0, 3, 0, 1'b0);
        check(slice_got == 0, "R8", "empty slice masks", slice_got, 0);
        run_slice(5, 2, 0, 1, 0, 1'b0);
        check(slice_got == 10, "R8", "restart after empty", slice_got, 10);
    endtask

    // R10: K=0 and K=N each yield one mask.
    task automatic t_extremes();
        run_slice(5, 0, 0, 1, 0, 1'b0);
        check(slice_got == 1, "R10", "K=0 count", slice_got, 1);
        run_slice(7, 7, 0, 1, 0, 1'b0);
        check(slice_got == 1, "R10", "K=N count", slice_got, 1);
    endtask

    // R9: start ignored mid-stream.
    task automatic t_ignore();
        run_slice(6, 2, 0, 1, 1, 1'b1);
        check(slice_got == 15, "R9", "stream unchanged by start", slice_got, 15);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_split();
        t_deep();
        t_empty();
        t_extremes();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule